// File: doc/BRIEF.md
# Undocumented Opcode Classifier with Halt Latch

This block sits beside the instruction decoder of an 8-bit processor core. It looks at the current 8-bit opcode and reports, without any clock delay, which undocumented group the opcode belongs to. The groups are:

- a no-operand no-op;
- a no-op that still fetches an operand;
- a jam (halt) code;
- a combined read-modify-write-then-accumulator operation;
- any other undocumented operation.

Every opcode outside these groups is reported as documented. For the two no-op groups it also gives a base cycle count. For every opcode it raises a flag when the operand is an immediate byte, which has no effective address.

The control unit asserts `op_valid` when the opcode is decoded for execution. If that opcode is a jam code, a sticky halt flag is set at that clock edge. From then on the fetch enable stays low. Only a synchronous reset clears the halt flag; further opcodes do not clear it. Classification keeps working while the core is halted.

Top module: `illegal_op_classifier`

## Requirements
- R1: Opcodes 0x02, 0x12, 0x22, 0x32, 0x42, 0x52, 0x62, 0x72, 0x92, 0xB2, 0xD2 and 0xF2 assert class bit 3 (jam).
- R2: Opcodes 0x1A, 0x3A, 0x5A, 0x7A, 0xDA and 0xFA assert class bit 1 (no-operand no-op) and drive `base_cycles` to 2.
- R3: Opcodes 0x04, 0x0C, 0x14, 0x1C, 0x34, 0x3C, 0x44, 0x54, 0x5C, 0x64, 0x74, 0x7C, 0x80, 0x82, 0x89, 0xC2, 0xD4, 0xDC, 0xE2, 0xF4 and 0xFC assert class bit 2 (operand no-op). `base_cycles` depends on the low five opcode bits: 0x00, 0x02 or 0x09 gives 2; 0x04 gives 3; 0x0C, 0x14 or 0x1C gives 4.
- R4: Class bit 4 (read-modify-write combo) is asserted for two sets of opcodes. The first is 0x03, 0x07, 0x0F, 0x13, 0x17, 0x1B and 0x1F. The second is the same seven codes plus 0x20, 0x40, 0x60, 0xC0 or 0xE0.
- R5: Class bit 5 (other undocumented) is asserted for 0x9C, 0x9E, and every opcode whose low two bits are 11 that R4 does not cover.
- R6: Any opcode not named in R1 to R5 asserts class bit 0 (documented). For every opcode exactly one of the six class bits is high.
- R7: `imm_operand` is high exactly when the operand is an immediate byte. That is the case when the low five bits are 0x09 or 0x0B, or when bit 7 is set and the low five bits are 0x00 or 0x02.
- R8: `base_cycles` is 0 for every opcode outside the two no-op classes.
- R9: An edge with `op_valid` high and a jam opcode sets `halted` at that edge. While `halted` is high, `fetch_en` is low.
- R10: Once set, `halted` stays high whatever is on `op_valid` and `opcode`, until an edge with `rst_n` low. A jam opcode with `op_valid` low does not set it.
- R11: After an edge with `rst_n` low, `halted` is 0 and `fetch_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode is being decoded for execution this cycle |
| opcode | input | 8 | Opcode byte under decode |
| op_class | output | 6 | One-hot class: 0 documented, 1 no-operand no-op, 2 operand no-op, 3 jam, 4 RMW combo, 5 other |
| base_cycles | output | CYC_W (3) | Base cycle count for no-op classes, else 0 |
| imm_operand | output | 1 | Operand is immediate and has no effective address |
| halted | output | 1 | Sticky halt flag |
| fetch_en | output | 1 | Instruction fetch permitted |

## Verification
Combinational classification and the halt latch both act in the cycle of a jam decode. The output that cycle must show the jam class while `halted` is still low. `halted` and `fetch_en` only change at the following edge. The bench presents a strobed jam, then sweeps all 256 opcodes with the latch already set. The class outputs must still match the reference for every opcode. `halted` must stay high throughout, including while more jam codes are strobed.

// File: rtl/ioc_pkg.sv
// Shared constants and opcode group lists for the undocumented opcode classifier.
// Assumes an 8-bit opcode; every list is written out in full as a case table.
package ioc_pkg;

    localparam int OP_W     = 8;
    localparam int NCLASS   = 6;
    localparam int CL_DOC   = 0;
    localparam int CL_IMPL  = 1;
    localparam int CL_ANOP  = 2;
    localparam int CL_JAM   = 3;
    localparam int CL_RMW   = 4;
    localparam int CL_OTHER = 5;

    // Jam codes that stop the core.
    function automatic logic is_jam_op(input logic [OP_W-1:0] op);
        case (op)
            8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52,
            8'h62, 8'h72, 8'h92, 8'hB2, 8'hD2, 8'hF2: is_jam_op = 1'b1;
            default:                                  is_jam_op = 1'b0;
        endcase
    endfunction

    // No-ops with no operand bytes.
    function automatic logic is_impl_nop(input logic [OP_W-1:0] op);
        case (op)
            8'h1A, 8'h3A, 8'h5A, 8'h7A, 8'hDA, 8'hFA: is_impl_nop = 1'b1;
            default:                                  is_impl_nop = 1'b0;
        endcase
    endfunction

    // No-ops that still fetch an operand.
    function automatic logic is_addr_nop(input logic [OP_W-1:0] op);
        case (op)
            8'h04, 8'h44, 8'h64, 8'h0C,
            8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4,
            8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC,
            8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2:        is_addr_nop = 1'b1;
            default:                                  is_addr_nop = 1'b0;
        endcase
    endfunction

    // Shift/rotate/inc/dec of memory merged with an accumulator operation.
    function automatic logic is_rmw_combo(input logic [OP_W-1:0] op);
        case (op)
            8'h03, 8'h07, 8'h0F, 8'h13, 8'h17, 8'h1B, 8'h1F,
            8'h23, 8'h27, 8'h2F, 8'h33, 8'h37, 8'h3B, 8'h3F,
            8'h43, 8'h47, 8'h4F, 8'h53, 8'h57, 8'h5B, 8'h5F,
            8'h63, 8'h67, 8'h6F, 8'h73, 8'h77, 8'h7B, 8'h7F,
            8'hC3, 8'hC7, 8'hCF, 8'hD3, 8'hD7, 8'hDB, 8'hDF,
            8'hE3, 8'hE7, 8'hEF, 8'hF3, 8'hF7, 8'hFB, 8'hFF: is_rmw_combo = 1'b1;
            default:                                         is_rmw_combo = 1'b0;
        endcase
    endfunction

    // Remaining undocumented operations (store-and, load-both, immediate logic ops).
    function automatic logic is_other_undoc(input logic [OP_W-1:0] op);
        case (op)
            8'h83, 8'h87, 8'h8F, 8'h97, 8'h93, 8'h9F, 8'h9B, 8'hBB,
            8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF,
            8'h0B, 8'h2B, 8'h4B, 8'h6B, 8'h8B, 8'hAB, 8'hCB, 8'hEB,
            8'h9C, 8'h9E:                                    is_other_undoc = 1'b1;
            default:                                         is_other_undoc = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ioc_group_decode.sv
// Group decoder: turns an opcode into a one-hot class vector.
// Assumes the package lists are disjoint; documented is the fall-through class.
module ioc_group_decode
    import ioc_pkg::*;
(
    input  logic [OP_W-1:0]   opcode,
    output logic [NCLASS-1:0] op_class
);

    // Raw membership of each undocumented group.
    logic [NCLASS-1:0] hit;

    // Evaluate each list against the opcode.
    always_comb begin
        hit            = '0;
        hit[CL_IMPL]   = is_impl_nop(opcode);
        hit[CL_ANOP]   = is_addr_nop(opcode);
        hit[CL_JAM]    = is_jam_op(opcode);
        hit[CL_RMW]    = is_rmw_combo(opcode);
        hit[CL_OTHER]  = is_other_undoc(opcode);
        hit[CL_DOC]    = ~|hit[NCLASS-1:1];
    end

    // Pass each class bit out through one lane per class.
    for (genvar g = 0; g < NCLASS; g++) begin : g_lane
        assign op_class[g] = hit[g];
    end

endmodule

// File: rtl/ioc_nop_timing.sv
// No-op timing and operand-type decode.
// Gives the base cycle count for the no-op classes from the addressing column
// (low five opcode bits) and flags immediate operands that carry no address.
module ioc_nop_timing
    import ioc_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic [OP_W-1:0]  opcode,
    input  logic             impl_nop,
    input  logic             addr_nop,
    output logic [CYC_W-1:0] base_cycles,
    output logic             imm_operand
);

    localparam int COL_W = 5;

    logic [COL_W-1:0] col;
    logic [CYC_W-1:0] mode_cycles;

    assign col = opcode[COL_W-1:0];

    // Base cycles per addressing column for operand-fetching no-ops.
    always_comb begin
        case (col)
            5'h00, 5'h02, 5'h09: mode_cycles = CYC_W'(2);
            5'h04:               mode_cycles = CYC_W'(3);
            5'h0C, 5'h14, 5'h1C: mode_cycles = CYC_W'(4);
            default:             mode_cycles = '0;
        endcase
    end

    // Select the cycle count by class; zero for everything else.
    always_comb begin
        if (impl_nop)      base_cycles = CYC_W'(2);
        else if (addr_nop) base_cycles = mode_cycles;
        else               base_cycles = '0;
    end

    // Immediate-operand flag: such operands have no effective address.
    always_comb begin
        case (col)
            5'h09, 5'h0B: imm_operand = 1'b1;
            5'h00, 5'h02: imm_operand = opcode[OP_W-1];
            default:      imm_operand = 1'b0;
        endcase
    end

endmodule

// File: rtl/ioc_halt_latch.sv
// Sticky halt latch: set by a strobed jam opcode, cleared only by synchronous reset.
// Assumes jam_hit comes combinationally from the current opcode.
module ioc_halt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic jam_hit,
    output logic halted
);

    // Hold the halt state until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  halted <= 1'b0;
        else if (op_valid && jam_hit) halted <= 1'b1;
    end

    // R9
    jam_sets_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && jam_hit) |=> halted);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    no_spurious_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !(op_valid && jam_hit)) |=> !halted);

endmodule

// File: rtl/illegal_op_classifier.sv
// Top level: classifies undocumented opcodes, supplies no-op base cycles and the
// immediate flag, and blocks fetch after a strobed jam opcode until reset.
// Assumes op_valid is asserted once per executed opcode.
module illegal_op_classifier
    import ioc_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    output logic [5:0]        op_class,
    output logic [CYC_W-1:0]  base_cycles,
    output logic              imm_operand,
    output logic              halted,
    output logic              fetch_en
);

    ioc_group_decode u_group (
        .opcode   (opcode),
        .op_class (op_class)
    );

    ioc_nop_timing #(.CYC_W(CYC_W)) u_timing (
        .opcode      (opcode),
        .impl_nop    (op_class[CL_IMPL]),
        .addr_nop    (op_class[CL_ANOP]),
        .base_cycles (base_cycles),
        .imm_operand (imm_operand)
    );

    ioc_halt_latch u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .jam_hit  (op_class[CL_JAM]),
        .halted   (halted)
    );

    // Fetch is allowed only while not halted.
    assign fetch_en = ~halted;

    // R6
    one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op_class) == 1);

    // R2
    impl_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class[CL_IMPL] |-> base_cycles == CYC_W'(2));

    // R3
    imm_nop_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_operand && op_class[CL_ANOP]) |-> base_cycles == CYC_W'(2));

    // R8
    non_nop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_class[CL_IMPL] || op_class[CL_ANOP]) |-> base_cycles == '0);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!halted && fetch_en));

endmodule

// File: tb/illegal_op_classifier_tb.sv
`timescale 1ns/1ps
module illegal_op_classifier_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [5:0] op_class;
    logic [2:0] base_cycles;
    logic       imm_operand;
    logic       halted;
    logic       fetch_en;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    illegal_op_classifier #(.CYC_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .op_class(op_class), .base_cycles(base_cycles), .imm_operand(imm_operand),
        .halted(halted), .fetch_en(fetch_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference class vector from the requirement text (structural form).
    function automatic logic [5:0] ref_class(input logic [7:0] op);
        logic [4:0] c;
        logic jam, impl, anop, rmw, oth;
        c    = op[4:0];
        jam  = (c == 5'h02 && !op[7]) || c == 5'h12;
        impl = (c == 5'h1A) && op[7:6] != 2'b10;
        anop = (c == 5'h04 && (op[7:5] == 3'd0 || op[7:5] == 3'd2 || op[7:5] == 3'd3))
             || op == 8'h0C
             || ((c == 5'h14 || c == 5'h1C) && op[7:6] != 2'b10)
             || op == 8'h80 || op == 8'h82 || op == 8'h89 || op == 8'hC2 || op == 8'hE2;
        rmw  = op[1:0] == 2'b11 && op[7:6] != 2'b10 && c != 5'h0B;
        oth  = (op[1:0] == 2'b11 && !rmw) || op == 8'h9C || op == 8'h9E;
        ref_class = {oth, rmw, jam, anop, impl, !(jam | impl | anop | rmw | oth)};
    endfunction

    function automatic logic [2:0] ref_cycles(input logic [7:0] op);
        logic [5:0] k;
        k = ref_class(op);
        if (k[1]) return 3'd2;
        if (!k[2]) return 3'd0;
        case (op[4:0])
            5'h04:   return 3'd3;
            5'h0C, 5'h14, 5'h1C: return 3'd4;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic ref_imm(input logic [7:0] op);
        return op[4:0] == 5'h09 || op[4:0] == 5'h0B
            || (op[7] && (op[4:0] == 5'h00 || op[4:0] == 5'h02));
    endfunction

    function automatic string class_req(input logic [5:0] k);
        if (k[3]) return "R1";
        if (k[1]) return "R2";
        if (k[2]) return "R3";
        if (k[4]) return "R4";
        if (k[5]) return "R5";
        return "R6";
    endfunction

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(halted == 1'b0, "R11", "halted after reset", halted, 0);
        chk(fetch_en == 1'b1, "R11", "fetch_en after reset", fetch_en, 1);
    endtask

    // Sweep all opcodes; expect_halt gives the halt level that must hold throughout.
    task automatic t_sweep(input logic strobe, input logic expect_halt);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            opcode   = 8'(i);
            op_valid = strobe;
            #1;
            chk(op_class == ref_class(8'(i)), class_req(ref_class(8'(i))),
                $sformatf("class of %02h", i), op_class, ref_class(8'(i)));
            chk(base_cycles == ref_cycles(8'(i)),
                ref_class(8'(i))[2] ? "R3" : (ref_class(8'(i))[1] ? "R2" : "R8"),
                $sformatf("cycles of %02h", i), base_cycles, ref_cycles(8'(i)));
            chk(imm_operand == ref_imm(8'(i)), "R7",
                $sformatf("imm of %02h", i), imm_operand, ref_imm(8'(i)));
            chk(halted == expect_halt, "R10", $sformatf("halt during sweep at %02h", i),
                halted, expect_halt);
        end
        @(negedge clk);
        op_valid = 1'b0;
        opcode   = 8'hEA;
        #1;
        chk(halted == expect_halt, "R10", "halt after sweep", halted, expect_halt);
    endtask

    // R9: strobed jam sets halt at the next edge, not before.
    task automatic t_jam(input logic [7:0] op);
        @(negedge clk);
        opcode   = op;
        op_valid = 1'b1;
        #1;
        chk(op_class == 6'b001000, "R1", "jam class in strobe cycle", op_class, 6'b001000);
        chk(halted == 1'b0, "R9", "halt not yet set before edge", halted, 0);
        @(negedge clk);
        op_valid = 1'b0;
        opcode   = 8'hA9;
        #1;
        chk(halted == 1'b1, "R9", "halt set after edge", halted, 1);
        chk(fetch_en == 1'b0, "R9", "fetch blocked", fetch_en, 0);
    endtask

    // R10: sticky across strobes of documented and undocumented codes.
    task automatic t_sticky();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            op_valid = i[0];
            opcode   = (i < 3) ? 8'hEA : 8'h1A;
        end
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk(halted == 1'b1, "R10", "halt stays set", halted, 1);
        chk(fetch_en == 1'b0, "R10", "fetch stays blocked", fetch_en, 0);
    endtask

    initial begin
        t_reset();
        // R1..R8 sweep with op_valid low; R10: jam without strobe must not halt.
        t_sweep(1'b0, 1'b0);
        t_jam(8'h02);
        t_sticky();
        // Same-cycle interaction: classification while halted and jams re-strobed.
        t_sweep(1'b1, 1'b1);
        t_reset();
        t_jam(8'hF2);
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule